// File: doc/BRIEF.md
# Dual-core command register bank

This block sits behind a serial front end that has already decoded each frame into one command: convert a channel, write a register, or read a register. Two identical 32-channel cores, A and B, act on every command together, and each produces its own 16-bit result word per frame. A conversion of channel X makes core A sample channel X while core B samples channel X+32. Analog conversion is not modelled; each core returns a fixed stub word that encodes the channel it would have sampled.

The block holds a six-bit address space of byte-wide registers. Addresses 0 to 21 are writable storage. They drive the impedance-check amplifier select and 64 per-amplifier power enables. A set of read-only addresses returns identification bytes. The upper four power registers read back correctly only on core B, and the signal-integrity marker returns a different byte on each core. Writable registers are not cleared by reset. Results are pipelined, so the word for a command appears two frames later on the serial link.

Top module: `dual_core_regbank`

## Requirements
- R1: While `rst` is high at a rising clock edge, both result words are 16'h0000 after that edge.
- R2: The result words of the command accepted at edge n (`cmd_valid` high) appear after the edge that accepts the next command. They stay unchanged in every cycle where `cmd_valid` is low.
- R3: A convert (`cmd_op` 2'b00) of channel X < 32 yields {STUB_TAG, 3'b000, X[4:0]} on A and {STUB_TAG, 3'b001, X[4:0]} on B, which is channel X+32.
- R4: A convert of X >= 32 (auxiliary and sensor channels) yields {STUB_TAG, 2'b01, X[5:0]} on A, and 16'h0000 on B.
- R5: A write (`cmd_op` 2'b01) to an address below 18 stores the byte. A read (`cmd_op` 2'b10) of that address returns {8'h00, value} on both words. A write's own result word is the readback of its address including that write.
- R6: Bits 5:0 of register 7 drive `zcheck_sel` from the cycle after the write.
- R7: Register 14+k (k = 0..3), bit j drives `amp_pwr_en[8k+j]`.
- R8: Register 18+k (k = 0..3), bit 7-j drives `amp_pwr_en[32+8k+j]`, so bit 7 maps to the lowest channel of each group.
- R9: Readback of registers 18 to 21 returns the stored byte on B and 8'h00 on A.
- R10: Read-only addresses 40..44 return 8'h49, 8'h4E, 8'h54, 8'h41, 8'h4E. Address 61 returns 1, 62 returns 64 and 63 returns 4, on both words.
- R11: Address 59 returns 53 on A and 58 on B.
- R12: A write to an address of 22 or above changes nothing. Its result word shows the unchanged contents. Addresses 22..39, 45..58 and 60 read as zero.
- R13: `cmd_op` 2'b11 changes no register and yields 16'h0000 on both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the result pipeline |
| cmd_valid | input | 1 | One-cycle pulse per decoded frame |
| cmd_op | input | 2 | 00 convert, 01 write, 10 read, 11 no operation |
| cmd_addr | input | 6 | Channel number or register address |
| cmd_data | input | 8 | Write data |
| res_a | output | 16 | Core A result word |
| res_b | output | 16 | Core B result word |
| zcheck_sel | output | 6 | Amplifier selected for impedance testing |
| amp_pwr_en | output | 64 | Per-amplifier power enables |

## Verification
The bench builds the block with its default stub tag of 8'hC0 and the fixed 32-channels-per-core geometry. With these values every one of the 64 addresses and every convert channel can be reached in a few hundred frames. The bench sweeps all addresses and both halves of the channel space exhaustively, then runs a randomised stream. That stream mixes back-to-back frames with idle gaps, so the two-frame latency and the hold behaviour are exercised together with every readback variant.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int ADDR_W            = 6;
    localparam int BYTE_W            = 8;
    localparam int WORD_W            = 16;
    localparam int NUM_CORES         = 2;
    localparam int CH_PER_CORE       = 32;
    localparam int NUM_AMPS          = NUM_CORES * CH_PER_CORE;
    localparam int ZSEL_W            = $clog2(NUM_AMPS);
    localparam int PWR_REGS_PER_CORE = CH_PER_CORE / BYTE_W;
    localparam int REG_ZSEL          = 7;
    localparam int REG_PWR_A         = 14;
    localparam int REG_PWR_B         = REG_PWR_A + PWR_REGS_PER_CORE;
    localparam int NUM_RAM           = REG_PWR_B + PWR_REGS_PER_CORE;

    typedef enum logic [1:0] {
        OP_CONV  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_IDLE  = 2'b11
    } op_e;

    typedef enum logic {
        CORE_A = 1'b0,
        CORE_B = 1'b1
    } core_e;

    typedef struct packed {
        op_e                op;
        logic [ADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]  data;
    } cmd_t;

    typedef logic [NUM_RAM-1:0][BYTE_W-1:0]          ram_t;
    typedef logic [NUM_CORES-1:0][WORD_W-1:0]        lane_words_t;

    // Identification bytes; zero for any address without a fixed value.
    function automatic logic [BYTE_W-1:0] rom_lookup(core_e core, logic [ADDR_W-1:0] addr);
        logic [BYTE_W-1:0] v;
        case (addr)
            6'd40:   v = 8'h49;
            6'd41:   v = 8'h4E;
            6'd42:   v = 8'h54;
            6'd43:   v = 8'h41;
            6'd44:   v = 8'h4E;
            6'd59:   v = (core == CORE_A) ? 8'd53 : 8'd58;
            6'd61:   v = 8'd1;
            6'd62:   v = BYTE_W'(NUM_AMPS);
            6'd63:   v = 8'd4;
            default: v = '0;
        endcase
        return v;
    endfunction

    // Stand-in for a conversion: {tag, 0, aux, channel}.
    function automatic logic [WORD_W-1:0] conv_stub(core_e core, logic [ADDR_W-1:0] addr,
                                                    logic [BYTE_W-1:0] tag);
        logic [WORD_W-1:0] w;
        if (!addr[ADDR_W-1])
            w = {tag, 2'b00, (core == CORE_B), addr[ADDR_W-2:0]};
        else if (core == CORE_A)
            w = {tag, 2'b01, addr};
        else
            w = '0;
        return w;
    endfunction

endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import regbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  cmd_t                 cmd,
    output ram_t                 ram_q,
    output logic [ZSEL_W-1:0]    zcheck_sel,
    output logic [NUM_AMPS-1:0]  amp_pwr_en
);

    logic we;
    assign we = cmd_valid && (cmd.op == OP_WRITE);

    // Writable storage has no reset: contents are undefined until written.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int r = 0; r < NUM_RAM; r++) begin
                if (cmd.addr == ADDR_W'(r))
                    ram_q[r] <= cmd.data;
            end
        end
    end

    assign zcheck_sel = ram_q[REG_ZSEL][ZSEL_W-1:0];

    for (genvar k = 0; k < PWR_REGS_PER_CORE; k++) begin : g_pwr_reg
        for (genvar j = 0; j < BYTE_W; j++) begin : g_pwr_bit
            assign amp_pwr_en[k*BYTE_W + j]               = ram_q[REG_PWR_A + k][j];
            assign amp_pwr_en[CH_PER_CORE + k*BYTE_W + j] = ram_q[REG_PWR_B + k][BYTE_W-1-j];
        end
    end

    AST_ZSEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (we && cmd.addr == ADDR_W'(REG_ZSEL)) |=> (zcheck_sel == $past(cmd.data[ZSEL_W-1:0]))); // R6

    AST_PWR_LOW_ORDER: assert property (@(posedge clk) disable iff (rst)
        (we && cmd.addr == ADDR_W'(REG_PWR_A)) |=> (amp_pwr_en[BYTE_W-1:0] == $past(cmd.data))); // R7

    AST_PWR_HIGH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (we && cmd.addr == ADDR_W'(REG_PWR_B)) |=>
        (amp_pwr_en[CH_PER_CORE] == $past(cmd.data[BYTE_W-1]) &&
         amp_pwr_en[CH_PER_CORE+BYTE_W-1] == $past(cmd.data[0]))); // R8

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(we && cmd.addr < ADDR_W'(NUM_RAM)) |=> ($stable(amp_pwr_en) && $stable(zcheck_sel))); // R12 R13

endmodule

// File: rtl/core_lane.sv
module core_lane
    import regbank_pkg::*;
#(
    parameter core_e             CORE_ID  = CORE_A,
    parameter logic [BYTE_W-1:0] STUB_TAG = 8'hC0
)(
    input  cmd_t               cmd,
    input  ram_t               ram_q,
    output logic [WORD_W-1:0]  word
);

    localparam logic [ADDR_W-1:0] HI_FIRST = ADDR_W'(REG_PWR_B);
    localparam logic [ADDR_W-1:0] RAM_END  = ADDR_W'(NUM_RAM);

    logic              ram_hit;
    logic              b_only;
    logic [BYTE_W-1:0] ram_val;
    logic [BYTE_W-1:0] rd_byte;

    // A write reports the value it leaves behind, so the new byte bypasses storage.
    always_comb begin
        ram_hit = 1'b0;
        ram_val = '0;
        for (int r = 0; r < NUM_RAM; r++) begin
            if (cmd.addr == ADDR_W'(r)) begin
                ram_hit = 1'b1;
                ram_val = (cmd.op == OP_WRITE) ? cmd.data : ram_q[r];
            end
        end
    end

    assign b_only  = (CORE_ID == CORE_A) && (cmd.addr >= HI_FIRST) && (cmd.addr < RAM_END);
    assign rd_byte = ram_hit ? (b_only ? '0 : ram_val) : rom_lookup(CORE_ID, cmd.addr);

    always_comb begin
        case (cmd.op)
            OP_CONV:           word = conv_stub(CORE_ID, cmd.addr, STUB_TAG);
            OP_WRITE, OP_READ: word = {{(WORD_W-BYTE_W){1'b0}}, rd_byte};
            default:           word = '0;
        endcase
    end

endmodule

// File: rtl/result_pipe.sv
module result_pipe
    import regbank_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  lane_words_t  in_words,
    output lane_words_t  out_words
);

    lane_words_t stage1;
    lane_words_t stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else if (adv) begin
            stage1 <= in_words;
            stage2 <= stage1;
        end
    end

    assign out_words = stage2;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (out_words == '0)); // R1

    AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(out_words)); // R2

endmodule

// File: rtl/dual_core_regbank.sv
module dual_core_regbank
    import regbank_pkg::*;
#(
    parameter logic [7:0] STUB_TAG = 8'hC0
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic [5:0]   cmd_addr,
    input  logic [7:0]   cmd_data,
    output logic [15:0]  res_a,
    output logic [15:0]  res_b,
    output logic [5:0]   zcheck_sel,
    output logic [63:0]  amp_pwr_en
);

    cmd_t        cmd;
    ram_t        ram_q;
    lane_words_t lane_word;
    lane_words_t out_words;

    assign cmd = '{op: op_e'(cmd_op), addr: cmd_addr, data: cmd_data};

    cfg_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .ram_q      (ram_q),
        .zcheck_sel (zcheck_sel),
        .amp_pwr_en (amp_pwr_en)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        core_lane #(
            .CORE_ID  (core_e'(c)),
            .STUB_TAG (STUB_TAG)
        ) u_lane (
            .cmd   (cmd),
            .ram_q (ram_q),
            .word  (lane_word[c])
        );
    end

    result_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .adv       (cmd_valid),
        .in_words  (lane_word),
        .out_words (out_words)
    );

    assign res_a = out_words[CORE_A];
    assign res_b = out_words[CORE_B];

endmodule

// File: tb/test_dual_core_regbank.sv
module test_dual_core_regbank;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] TAG        = 8'hC0;
    localparam int         N_RAM      = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b11;
    logic [5:0]  cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [15:0] res_a, res_b;
    logic [5:0]  zcheck_sel;
    logic [63:0] amp_pwr_en;

    dual_core_regbank #(.STUB_TAG(TAG)) i_dual_core_regbank (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .res_a(res_a), .res_b(res_b),
        .zcheck_sel(zcheck_sel), .amp_pwr_en(amp_pwr_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    logic [7:0]  mreg [N_RAM];
    bit          mknown [N_RAM];
    logic [15:0] exp_a = '0, exp_b = '0, last_a = '0, last_b = '0;
    string       exp_tag = "R1", last_tag = "R1";

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [7:0] model_rd(bit core_b, int addr);
        if (addr < 18) return mreg[addr];
        if (addr < N_RAM) return core_b ? mreg[addr] : 8'h00;
        case (addr)
            40: return 8'h49;
            41: return 8'h4E;
            42: return 8'h54;
            43: return 8'h41;
            44: return 8'h4E;
            59: return core_b ? 8'd58 : 8'd53;
            61: return 8'd1;
            62: return 8'd64;
            63: return 8'd4;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] op, int addr);
        if (op == 2'b11) return "R13";
        if (op == 2'b00) return (addr < 32) ? "R3" : "R4";
        if (addr < 18) return "R5";
        if (addr < N_RAM) return "R9";
        if (addr == 59) return "R11";
        if ((addr >= 40 && addr <= 44) || addr >= 61) return "R10";
        return "R12";
    endfunction

    function automatic logic [63:0] model_pwr();
        logic [63:0] p;
        for (int ch = 0; ch < 64; ch++) begin
            if (ch < 32) p[ch] = mreg[14 + ch/8][ch%8];
            else         p[ch] = mreg[18 + (ch-32)/8][7 - ((ch-32)%8)];
        end
        return p;
    endfunction

    // Reference model, advanced on every clock and compared just after the edge.
    always @(posedge clk) begin
        if (!done) begin
            if (rst) begin
                exp_a = '0; exp_b = '0; last_a = '0; last_b = '0;
                exp_tag = "R1"; last_tag = "R1";
            end else if (cmd_valid) begin
                int a;
                a = int'(cmd_addr);
                exp_a = last_a; exp_b = last_b; exp_tag = last_tag;
                last_tag = tag_of(cmd_op, a);
                case (cmd_op)
                    2'b00: begin
                        if (a < 32) begin
                            last_a = {TAG, 3'b000, cmd_addr[4:0]};
                            last_b = {TAG, 3'b001, cmd_addr[4:0]};
                        end else begin
                            last_a = {TAG, 2'b01, cmd_addr};
                            last_b = 16'h0000;
                        end
                    end
                    2'b01, 2'b10: begin
                        if (cmd_op == 2'b01 && a < N_RAM) begin
                            mreg[a] = cmd_data;
                            mknown[a] = 1'b1;
                        end
                        last_a = {8'h00, model_rd(1'b0, a)};
                        last_b = {8'h00, model_rd(1'b1, a)};
                    end
                    default: begin last_a = '0; last_b = '0; end
                endcase
            end
            #1;
            chk({exp_tag, " R2 word A"}, 64'(res_a), 64'(exp_a));
            chk({exp_tag, " R2 word B"}, 64'(res_b), 64'(exp_b));
            if (mknown[7]) chk("R6 zcheck_sel", 64'(zcheck_sel), 64'(mreg[7][5:0]));
            if (mknown[14] && mknown[15] && mknown[16] && mknown[17])
                chk("R7 power low half", 64'(amp_pwr_en[31:0]), 64'(model_pwr() & 64'hFFFF_FFFF));
            if (mknown[18] && mknown[19] && mknown[20] && mknown[21])
                chk("R8 power high half", 64'(amp_pwr_en[63:32]), 64'(model_pwr() >> 32));
        end
    end

    task automatic send(logic [1:0] op, logic [5:0] addr, logic [7:0] data, int gap);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N_RAM; i++) mknown[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset held
        chk("R1 reset A", 64'(res_a), 64'h0);
        chk("R1 reset B", 64'(res_b), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        // R5 R6 R7 R8 R9: fill all writable registers
        for (int r = 0; r < N_RAM; r++) send(2'b01, 6'(r), 8'(r*37 + 11), r % 2);
        send(2'b01, 6'd14, 8'h81, 0);   // R7 ordering
        send(2'b01, 6'd18, 8'h81, 1);   // R8 reversed ordering
        send(2'b01, 6'd19, 8'h0F, 0);
        send(2'b01, 6'd7, 8'hFF, 2);    // R6 upper bits dropped
        // R3 R4: conversions on both halves of channel space
        for (int x = 0; x < 64; x++) send(2'b00, 6'(x), 8'h00, x % 3);
        // R5 R9 R10 R11 R12: read every address
        for (int x = 0; x < 64; x++) send(2'b10, 6'(x), 8'h00, (x % 4 == 0) ? 1 : 0);
        // R12: writes to read-only and unimplemented addresses are ignored
        send(2'b01, 6'd40, 8'h00, 0);
        send(2'b01, 6'd59, 8'hAA, 0);
        send(2'b01, 6'd63, 8'h55, 0);
        send(2'b01, 6'd30, 8'h77, 0);
        send(2'b10, 6'd40, 8'h00, 0);
        send(2'b10, 6'd59, 8'h00, 0);
        send(2'b10, 6'd30, 8'h00, 0);
        // R13: no-operation commands
        send(2'b11, 6'd14, 8'h00, 0);
        send(2'b11, 6'd7, 8'h3C, 3);
        // R2: long idle gap, then random traffic
        repeat (5) @(negedge clk);
        for (int i = 0; i < 600; i++)
            send(2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)),
                 8'($urandom_range(0, 255)), int'($urandom_range(0, 3)));
        send(2'b11, 6'd0, 8'h00, 0);
        send(2'b11, 6'd0, 8'h00, 2);
        done = 1'b1;
        finish_run();
    end

endmodule